// File: doc/BRIEF.md
# Split Carry-Prefix Adder with Constant Upper Operand

This block is a purely combinational adder for the reconstruction stage of a residue-number converter. In that stage, one of the two addends has its upper bits fixed at a pattern known at design time. The adder is split at a parameterised bit position. In the low part, both operand bits vary, and the sum is formed with a Brent-Kung carry-prefix network. In the high part, the second operand is the constant pattern, so each position collapses to a two-gate ripple cell.

The incoming carry enters the prefix network as the generate term of an extra position below bit 0. The group carry leaving the prefix part feeds the first constant-operand cell. The chain of reduced cells then produces the upper sum bits and the final carry out. The block has no modulo wraparound, no pipelining and no state.

Top module: `hybrid_prefix_adder`

## Requirements
- R1: Bits SPLIT-1..0 of `sum` equal the low SPLIT bits of a[SPLIT-1:0] + b_lo + cin.
- R2: {cout, sum} equals a + {HI_CONST, b_lo} + cin as a (W+1)-bit unsigned value. The second operand is b_lo in bits SPLIT-1..0 and HI_CONST in bits W-1..SPLIT.
- R3: `cin` adds one at bit 0. With a = 0, b_lo = 0 and cin = 1, sum is {HI_CONST, SPLIT'(1)} and cout is 0.
- R4: A carry generated in the low part reaches the upper part. With a[SPLIT-1:0] all ones, b_lo = 0 and cin = 1, the low sum bits are 0 and the upper bits equal a[W-1:SPLIT] + HI_CONST + 1.
- R5: With no carry from the low part and a[W-1:SPLIT] = 0, sum[W-1:SPLIT] reproduces HI_CONST exactly, and cout is 0.
- R6: cout is 1 exactly when the true total exceeds 2^W - 1. With every input at its maximum, cout is 1.
- R7: R2 holds for any split point with 1 <= SPLIT < W and any constant pattern. This includes a narrow prefix part (SPLIT = 3) and a wide one (SPLIT = 11).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First addend, all bits variable |
| b_lo | input | SPLIT | Variable low bits of the second addend |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Sum bits |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The checks take for granted that every input is a known 0 or 1 whenever it is evaluated. Because the block has no clock, the checks also assume the inputs change only between evaluations and never settle mid-check. The stimulus holds all inputs at zero through reset. After that, it changes inputs only on the rising clock edge and reads results on the falling edge. Every value it drives is a defined two-state value, drawn from a fixed table or from the random generator.

// File: rtl/hybrid_prefix_adder.sv
module hybrid_prefix_adder #(
  parameter int W = 12,
  parameter int SPLIT = 6,
  parameter logic [W-SPLIT-1:0] HI_CONST = 6'b101101
) (
  input  logic [W-1:0]     a,
  input  logic [SPLIT-1:0] b_lo,
  input  logic             cin,
  output logic [W-1:0]     sum,
  output logic             cout
);
  localparam int N   = SPLIT + 1;
  localparam int L   = (N > 1) ? $clog2(N) : 1;
  localparam int STG = 2 * L - 1;
  localparam int HW  = W - SPLIT;

  logic [N-1:0]     gt [0:STG];
  logic [N-1:0]     pt [0:STG];
  logic [SPLIT-1:0] pb;
  logic [HW:0]      hc;
  logic             unused_p;

  assign pb    = a[SPLIT-1:0] ^ b_lo;
  assign gt[0] = {a[SPLIT-1:0] & b_lo, cin};
  assign pt[0] = {pb, 1'b0};

  genvar s, i;
  for (s = 0; s < STG; s++) begin : g_stage
    localparam bit UP = (s < L);
    localparam int LV = UP ? s : (2 * L - 2 - s);
    localparam int D  = 1 << LV;
    for (i = 0; i < N; i++) begin : g_node
      localparam bit ACT  = UP ? (((i + 1) % (2 * D)) == 0)
                               : ((((i + 1) % (2 * D)) == D) && (i + 1 > 2 * D));
      localparam bit GRAY = UP ? ((i + 1) == 2 * D) : 1'b1;
      if (ACT && GRAY) begin : g_gray
        assign gt[s+1][i] = gt[s][i] | (pt[s][i] & gt[s][i-D]);
        assign pt[s+1][i] = pt[s][i];
      end else if (ACT) begin : g_black
        assign gt[s+1][i] = gt[s][i] | (pt[s][i] & gt[s][i-D]);
        assign pt[s+1][i] = pt[s][i] & pt[s][i-D];
      end else begin : g_buf
        assign gt[s+1][i] = gt[s][i];
        assign pt[s+1][i] = pt[s][i];
      end
    end
  end

  assign unused_p         = ^pt[STG];
  assign sum[SPLIT-1:0]   = pb ^ gt[STG][SPLIT-1:0];
  assign hc[0]            = gt[STG][SPLIT];

  for (i = 0; i < HW; i++) begin : g_hi
    if (HI_CONST[i]) begin : g_one
      assign sum[SPLIT+i] = ~(a[SPLIT+i] ^ hc[i]);
      assign hc[i+1]      = a[SPLIT+i] | hc[i];
    end else begin : g_zero
      assign sum[SPLIT+i] = a[SPLIT+i] ^ hc[i];
      assign hc[i+1]      = a[SPLIT+i] & hc[i];
    end
  end

  assign cout = hc[HW];
endmodule

// File: rtl/hybrid_prefix_adder_chk.sv
module hybrid_prefix_adder_chk #(
  parameter int W = 12,
  parameter int SPLIT = 6,
  parameter logic [W-SPLIT-1:0] HI_CONST = 6'b101101
) (
  input logic [W-1:0]     a,
  input logic [SPLIT-1:0] b_lo,
  input logic             cin,
  input logic [W-1:0]     sum,
  input logic             cout
);
  logic [W:0]     tot;
  logic [SPLIT:0] lo;

  always_comb begin
    tot = {1'b0, a} + {1'b0, HI_CONST, b_lo} + (W+1)'(cin);
    lo  = {1'b0, a[SPLIT-1:0]} + {1'b0, b_lo} + (SPLIT+1)'(cin);
    if (!$isunknown({a, b_lo, cin, sum, cout})) begin
      AST_LOW_SUM: assert (sum[SPLIT-1:0] == lo[SPLIT-1:0]) else $error("low sum"); // R1
      AST_TOTAL_SUM: assert ({cout, sum} == tot) else $error("total sum"); // R2
      AST_CIN_UNIT: assert (!(a == '0 && b_lo == '0 && cin) || (sum == {HI_CONST, SPLIT'(1)} && !cout)) else $error("cin"); // R3
      AST_HI_PASS: assert (!(!lo[SPLIT] && a[W-1:SPLIT] == '0) || (sum[W-1:SPLIT] == HI_CONST && !cout)) else $error("hi pass"); // R5
      AST_COUT_RANGE: assert (cout == (tot > (W+1)'({W{1'b1}}))) else $error("cout"); // R6
    end
  end
endmodule

bind hybrid_prefix_adder hybrid_prefix_adder_chk #(.W(W), .SPLIT(SPLIT), .HI_CONST(HI_CONST)) u_chk (
  .a(a), .b_lo(b_lo), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/sim_hybrid_prefix_adder.sv
module sim_hybrid_prefix_adder;
  localparam logic [5:0] HI0 = 6'b101101;
  localparam logic [4:0] HI1 = 5'b00110;
  localparam logic [4:0] HI2 = 5'b11011;
  localparam int NV = 10;
  localparam logic [18:0] VEC [0:NV-1] = '{
    {12'h000, 6'h00, 1'b0}, {12'h001, 6'h01, 1'b0}, {12'h03F, 6'h01, 1'b0},
    {12'hFFF, 6'h3F, 1'b1}, {12'h555, 6'h2A, 1'b1}, {12'hAAA, 6'h15, 1'b0},
    {12'h4C0, 6'h00, 1'b0}, {12'h800, 6'h3F, 1'b1}, {12'h7FF, 6'h00, 1'b1},
    {12'h123, 6'h1C, 1'b1}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [11:0] a0 = '0; logic [5:0]  b0 = '0; logic c0 = 1'b0; logic [11:0] s0; logic o0;
  logic [7:0]  a1 = '0; logic [2:0]  b1 = '0; logic c1 = 1'b0; logic [7:0]  s1; logic o1;
  logic [15:0] a2 = '0; logic [10:0] b2 = '0; logic c2 = 1'b0; logic [15:0] s2; logic o2;

  always #4 clk = ~clk;

  hybrid_prefix_adder #(.W(12), .SPLIT(6),  .HI_CONST(HI0)) u0 (.a(a0), .b_lo(b0), .cin(c0), .sum(s0), .cout(o0));
  hybrid_prefix_adder #(.W(8),  .SPLIT(3),  .HI_CONST(HI1)) u1 (.a(a1), .b_lo(b1), .cin(c1), .sum(s1), .cout(o1));
  hybrid_prefix_adder #(.W(16), .SPLIT(11), .HI_CONST(HI2)) u2 (.a(a2), .b_lo(b2), .cin(c2), .sum(s2), .cout(o2));

  task automatic check(input string req, input logic [16:0] got, input logic [16:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run0(input logic [11:0] a, input logic [5:0] b, input logic c, input string req);
    @(posedge clk); a0 = a; b0 = b; c0 = c;
    @(negedge clk);
    check(req, 17'({o0, s0}), 17'(13'({1'b0, a}) + {1'b0, HI0, b} + 13'(c)));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset", 17'({o0, s0}), 17'({1'b0, HI0, 6'h00}));
    for (int k = 0; k < NV; k++) run0(VEC[k][18:7], VEC[k][6:1], VEC[k][0], "R2 table");
    run0(12'h000, 6'h00, 1'b1, "R3 cin");
    check("R3 value", 17'({o0, s0}), 17'({1'b0, HI0, 6'h01}));
    run0(12'h23F, 6'h00, 1'b1, "R4 low carry");
    check("R4 low zero", 17'(s0[5:0]), 17'(0));
    check("R4 upper", 17'(s0[11:6]), 17'(6'(6'h08 + HI0 + 6'd1)));
    run0(12'h01A, 6'h05, 1'b0, "R1 low only");
    check("R1 low bits", 17'(s0[5:0]), 17'(6'h1F));
    check("R5 hi const", 17'({o0, s0[11:6]}), 17'({1'b0, HI0}));
    run0(12'hFFF, 6'h3F, 1'b1, "R6 max");
    check("R6 cout set", 17'(o0), 17'(1));
    for (int k = 0; k < 200; k++) begin
      run0(12'($urandom), 6'($urandom), 1'($urandom), "R2 random");
      @(posedge clk); a1 = 8'($urandom); b1 = 3'($urandom); c1 = 1'($urandom);
      a2 = 16'($urandom); b2 = 11'($urandom); c2 = 1'($urandom);
      @(negedge clk);
      check("R7 split3", 17'({o1, s1}), 17'(9'({1'b0, a1}) + {1'b0, HI1, b1} + 9'(c1)));
      check("R7 split11", 17'({o2, s2}), 17'({1'b0, a2} + {1'b0, HI2, b2} + 17'(c2)));
    end
    @(posedge clk); a1 = 8'hFF; b1 = 3'h7; c1 = 1'b1; a2 = 16'hFFFF; b2 = 11'h7FF; c2 = 1'b1;
    @(negedge clk);
    check("R7 R6 split3 max", 17'({o1, s1}), 17'(9'h0FF + {1'b0, HI1, 3'h7} + 9'd1));
    check("R7 R6 split11 max", 17'({o2, s2}), 17'({1'b0, 16'hFFFF} + {1'b0, HI2, 11'h7FF} + 17'd1));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule